// File: doc/BRIEF.md
# Two-Granule Translation Table Walker

This block turns a 48-bit virtual address into a physical address by reading 64-bit descriptors from an in-memory translation table, one level at a time. Each walk picks one of two granule sizes through a configuration input. The small granule walks levels 0 through 3. The large granule walks levels 1 through 3. A request carries the virtual address, the base address of the first table and a flag that selects stage-2 permission rules. The block accepts a request only while it is idle.

At each level the walker forms a byte offset from a slice of the virtual address and adds it to the current table base. It issues one read over a valid/ready port and waits for the response. It then decodes the returned descriptor. A descriptor is one of three things: a pointer to the next table, a final mapping (a block or a page), or invalid. For a final mapping the block reports the physical address, the page mask and a writable flag. For an invalid descriptor it reports a translation fault tagged with its level. Either result appears for one cycle alongside a done pulse.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_rd_valid` and `done` are 0.
- R2: A walk starts at level 0 when `cfg_gran64`=0 and at level 1 when it is 1, and goes no deeper than level 3. The read address at each level is the table base plus 8 times an index field. The small granule takes the field from VA[47:39], VA[38:30], VA[29:21] and VA[20:12] for levels 0 to 3. The large granule takes it from VA[47:42], VA[41:29] and VA[28:16] for levels 1 to 3.
- R3: A table-pointer descriptor sets the next table base to descriptor bits 47:12 (small granule) or 47:16 (large granule), with all lower bits zero.
- R4: Descriptor bit 0 is the valid bit at levels 0 to 2. A level-3 descriptor is valid only when bits 0 and 1 are both 1.
- R5: At the first level of a granule, a valid descriptor with bit 1 = 1 is a table pointer and one with bit 1 = 0 is invalid. At any other level below 3, bit 1 = 1 means table and bit 1 = 0 means block. A valid level-3 descriptor is always a page.
- R6: An invalid descriptor ends the walk with `done_fault`=1 and `done_level` set to the level of that descriptor. In that case `done_pa`, `done_mask` and `done_wr` are all 0.
- R7: On a block or page, the output address is descriptor bits 47:N with lower bits zero. N is 30 or 21 at small-granule levels 1 and 2, 12 at small-granule level 3, 29 at large-granule level 2 and 16 at large-granule level 3. `done_pa` equals that address above the page mask, joined with the VA bits below it.
- R8: `done_mask` has ones above the page offset. The page offset is 30, 21 and 12 bits at small-granule levels 1, 2 and 3, and 29 and 16 bits at large-granule levels 2 and 3. When descriptor bit 52 is 1 at level 3, the offset widens to 16 bits (small granule) or 21 bits (large granule).
- R9: `done_wr` is 1 when descriptor bits 7:6 equal 2'b11 if the request's stage-2 flag was set, and when bit 7 is 0 otherwise.
- R10: While a walk is in progress, `req_ready` is 0 and at most one read is outstanding: no new read is issued until the previous response arrives. A read that is not yet accepted keeps `mem_rd_valid` high and its address unchanged.
- R11: `done` is high for exactly one cycle per walk. `req_ready` returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gran64 | input | 1 | Granule select, sampled at request accept: 0 small, 1 large |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 48 | Virtual address to translate |
| req_base | input | 48 | Base address of the first-level table |
| req_s2 | input | 1 | Apply stage-2 permission rule |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Descriptor returned by memory |
| done | output | 1 | One-cycle completion strobe |
| done_fault | output | 1 | Walk ended on an invalid descriptor |
| done_level | output | 2 | Level of the final descriptor |
| done_pa | output | 48 | Translated physical address |
| done_mask | output | 48 | Page mask, ones above the page offset |
| done_wr | output | 1 | Mapping is writable |

## Verification
The walker has no size parameters. Its address, descriptor and index widths are fixed by the package, so the bench builds it at its only configuration. That configuration is small enough to sweep. Both granules are covered. Every level at which a walk can end with a mapping is crossed with both settings of the size-widening bit, both permission stages and all four values of the permission bits. Every way of producing a fault (a clear valid bit, a level-3 entry without its second bit, a block at a first level) is tried at each level where it applies. Response latency and read backpressure are varied throughout, which brings the hold and single-outstanding rules into reach.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned AW    = 48;  // address width
  localparam int unsigned DW    = 64;  // descriptor width
  localparam int unsigned LW    = 2;   // level number width
  localparam int unsigned OFS_W = 16;  // byte offset into one table
  localparam int unsigned SH_W  = 5;   // width of a bit-shift amount
  localparam int unsigned SYN_N = 2;   // reset release stages

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_READ,
    WS_WAIT,
    WS_DONE
  } walk_st_e;

  typedef struct packed {
    logic            ok;     // usable at this level
    logic            leaf;   // block or page
    logic            wr;     // writable
    logic [SH_W-1:0] oa_sh;  // bits below the output address
    logic [SH_W-1:0] pg_sh;  // page offset width
    logic [AW-1:0]   nxt;    // next table base
  } dsc_info_t;
endpackage

// File: rtl/xlat_index.sv
module xlat_index
  import xlat_pkg::*;
(
  input  logic             g64,
  input  logic [LW-1:0]    lvl,
  input  logic [AW-1:0]    va,
  output logic [OFS_W-1:0] ofs
);
  localparam int unsigned IDX_W = OFS_W - 3;

  logic [IDX_W-1:0] idx;
  logic             unused_va;

  always_comb begin
    idx = '0;
    if (g64) begin
      case (lvl)
        2'd1:    idx = {7'd0, va[47:42]};
        2'd2:    idx = va[41:29];
        2'd3:    idx = va[28:16];
        default: idx = '0;
      endcase
    end else begin
      case (lvl)
        2'd0:    idx = {4'd0, va[47:39]};
        2'd1:    idx = {4'd0, va[38:30]};
        2'd2:    idx = {4'd0, va[29:21]};
        default: idx = {4'd0, va[20:12]};
      endcase
    end
  end

  assign ofs       = {idx, 3'b000};
  assign unused_va = ^va[11:0];
endmodule

// File: rtl/xlat_decode.sv
module xlat_decode
  import xlat_pkg::*;
(
  input  logic          g64,
  input  logic          s2,
  input  logic [LW-1:0] lvl,
  input  logic [DW-1:0] dsc,
  output dsc_info_t     info
);
  logic first_lvl;
  logic unused_dsc;

  assign first_lvl  = g64 ? (lvl == 2'd1) : (lvl == 2'd0);
  assign unused_dsc = ^{dsc[63:53], dsc[51:48], dsc[5:2]};

  always_comb begin
    info     = '0;
    info.wr  = s2 ? (dsc[7:6] == 2'b11) : ~dsc[7];
    info.nxt = g64 ? {dsc[47:16], 16'd0} : {dsc[47:12], 12'd0};

    if (lvl == 2'd3) begin
      info.ok   = dsc[0] & dsc[1];
      info.leaf = 1'b1;
    end else if (first_lvl) begin
      info.ok   = dsc[0] & dsc[1];
      info.leaf = 1'b0;
    end else begin
      info.ok   = dsc[0];
      info.leaf = ~dsc[1];
    end

    if (g64) begin
      case (lvl)
        2'd2: begin
          info.oa_sh = 5'd29;
          info.pg_sh = 5'd29;
        end
        default: begin
          info.oa_sh = 5'd16;
          info.pg_sh = dsc[52] ? 5'd21 : 5'd16;
        end
      endcase
    end else begin
      case (lvl)
        2'd1: begin
          info.oa_sh = 5'd30;
          info.pg_sh = 5'd30;
        end
        2'd2: begin
          info.oa_sh = 5'd21;
          info.pg_sh = 5'd21;
        end
        default: begin
          info.oa_sh = 5'd12;
          info.pg_sh = dsc[52] ? 5'd16 : 5'd12;
        end
      endcase
    end
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_gran64,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_va,
  input  logic [AW-1:0] req_base,
  input  logic          req_s2,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          done,
  output logic          done_fault,
  output logic [LW-1:0] done_level,
  output logic [AW-1:0] done_pa,
  output logic [AW-1:0] done_mask,
  output logic          done_wr
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  // reset: asserted at once, released through SYN_N flops
  logic [SYN_N-1:0] rs_q;
  logic             srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYN_N-2:0], 1'b1};
  end
  assign srst_n = rs_q[SYN_N-1];

  // walk state
  walk_st_e      st_q, st_n;
  logic [LW-1:0] lvl_q, lvl_n;
  logic [AW-1:0] tbl_q, tbl_n;
  logic [AW-1:0] va_q;
  logic          s2_q, g64_q;
  logic          ld_req, ld_res;

  // result registers
  logic          flt_q;
  logic [LW-1:0] rlvl_q;
  logic [AW-1:0] pa_q, msk_q;
  logic          wr_q;
  logic          flt_n, wr_n;
  logic [AW-1:0] pa_n, msk_n;

  logic [OFS_W-1:0] ofs;
  dsc_info_t        info;
  logic [AW-1:0]    oa, pmask;

  xlat_index u_index (
    .g64 (g64_q),
    .lvl (lvl_q),
    .va  (va_q),
    .ofs (ofs)
  );

  xlat_decode u_decode (
    .g64  (g64_q),
    .s2   (s2_q),
    .lvl  (lvl_q),
    .dsc  (mem_rsp_data),
    .info (info)
  );

  assign pmask = ~((ONE << info.pg_sh) - ONE);
  assign oa    = mem_rsp_data[AW-1:0] & ~((ONE << info.oa_sh) - ONE);

  // result of the descriptor now on the response port
  always_comb begin
    if (info.ok) begin
      flt_n = 1'b0;
      wr_n  = info.wr;
      msk_n = pmask;
      pa_n  = (oa & pmask) | (va_q & ~pmask);
    end else begin
      flt_n = 1'b1;
      wr_n  = 1'b0;
      msk_n = '0;
      pa_n  = '0;
    end
  end

  // next-state logic
  always_comb begin
    st_n   = st_q;
    lvl_n  = lvl_q;
    tbl_n  = tbl_q;
    ld_req = 1'b0;
    ld_res = 1'b0;
    case (st_q)
      WS_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          st_n   = WS_READ;
          lvl_n  = cfg_gran64 ? 2'd1 : 2'd0;
          tbl_n  = req_base;
        end
      end
      WS_READ: begin
        if (mem_rd_ready) st_n = WS_WAIT;
      end
      WS_WAIT: begin
        if (mem_rsp_valid) begin
          if (!info.ok || info.leaf) begin
            ld_res = 1'b1;
            st_n   = WS_DONE;
          end else begin
            st_n  = WS_READ;
            lvl_n = lvl_q + 2'd1;
            tbl_n = info.nxt;
          end
        end
      end
      default: st_n = WS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= WS_IDLE;
      lvl_q  <= '0;
      tbl_q  <= '0;
      va_q   <= '0;
      s2_q   <= 1'b0;
      g64_q  <= 1'b0;
      flt_q  <= 1'b0;
      rlvl_q <= '0;
      pa_q   <= '0;
      msk_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      st_q  <= st_n;
      lvl_q <= lvl_n;
      tbl_q <= tbl_n;
      if (ld_req) begin
        va_q  <= req_va;
        s2_q  <= req_s2;
        g64_q <= cfg_gran64;
      end
      if (ld_res) begin
        flt_q  <= flt_n;
        rlvl_q <= lvl_q;
        pa_q   <= pa_n;
        msk_q  <= msk_n;
        wr_q   <= wr_n;
      end
    end
  end

  assign req_ready    = (st_q == WS_IDLE) && srst_n;
  assign mem_rd_valid = (st_q == WS_READ);
  assign mem_rd_addr  = tbl_q + {{(AW-OFS_W){1'b0}}, ofs};
  assign done         = (st_q == WS_DONE);
  assign done_fault   = flt_q;
  assign done_level   = rlvl_q;
  assign done_pa      = pa_q;
  assign done_mask    = msk_q;
  assign done_wr      = wr_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
  import xlat_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic          done,
  input logic          done_fault,
  input logic [AW-1:0] done_mask,
  input logic          done_wr
);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_read_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd_valid);

  assert_fault_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault |-> !done_wr && (done_mask == '0));

  assert_mask_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_fault |-> done_mask[AW-1] && (done_mask[11:0] == 12'd0));
endmodule

bind xlat_walker xlat_walker_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .done         (done),
  .done_fault   (done_fault),
  .done_mask    (done_mask),
  .done_wr      (done_wr)
);

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_gran64 = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic [47:0] req_base = '0;
  logic        req_s2 = 1'b0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [47:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done, done_fault, done_wr;
  logic [1:0]  done_level;
  logic [47:0] done_pa, done_mask;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] dsq [4];

  always #10 clk = ~clk;  // 50 MHz

  xlat_walker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_gran64(cfg_gran64),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_base(req_base), .req_s2(req_s2),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
    .done_level(done_level), .done_pa(done_pa), .done_mask(done_mask),
    .done_wr(done_wr)
  );

  task automatic chk(input bit c, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // expected byte offset (R2)
  function automatic logic [47:0] e_ofs(bit g, int lv, logic [47:0] va);
    if (g) begin
      if (lv == 1) return {36'd0, va[47:42], 3'b0};
      if (lv == 2) return {32'd0, va[41:29], 3'b0};
      return {32'd0, va[28:16], 3'b0};
    end
    case (lv)
      0: return {36'd0, va[47:39], 3'b0};
      1: return {36'd0, va[38:30], 3'b0};
      2: return {36'd0, va[29:21], 3'b0};
      default: return {36'd0, va[20:12], 3'b0};
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    mem_rd_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one walk; dsq holds the descriptors in level order
  task automatic walk(input bit g, input bit s2, input logic [47:0] va,
                      input logic [47:0] base, input int lat, input int hold);
    int          first = g ? 1 : 0;
    logic [47:0] tbl = base;
    logic [47:0] a0;
    logic [63:0] d;
    bit          fin = 0, e_flt = 0, e_wr = 0;
    int          lv = first, k = 0, osh = 0, psh = 0;
    logic [47:0] e_pa = '0, e_msk = '0, oa;
    bit          seen;

    chk(req_ready === 1'b1, "R11 idle before request", {63'd0, req_ready}, 64'd1);
    cfg_gran64 = g; req_s2 = s2; req_va = va; req_base = base; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_va = rnd64(); req_base = rnd64(); req_s2 = ~s2; cfg_gran64 = ~g;
    chk(req_ready === 1'b0, "R10 busy after accept", {63'd0, req_ready}, 64'd0);

    while (!fin) begin
      seen = 0;
      for (int w = 0; w < 40; w++) begin
        if (mem_rd_valid === 1'b1) begin seen = 1; break; end
        @(negedge clk);
      end
      chk(seen, "R2 read issued at level", {62'd0, lv[1:0]}, 64'd1);
      if (!seen) begin do_reset(); return; end
      chk(mem_rd_addr === tbl + e_ofs(g, lv, va), "R2 R3 read address",
          {16'd0, mem_rd_addr}, {16'd0, tbl + e_ofs(g, lv, va)});
      a0 = mem_rd_addr;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(mem_rd_valid === 1'b1 && mem_rd_addr === a0, "R10 read held",
            {16'd0, mem_rd_addr}, {16'd0, a0});
      end
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0;
      for (int t = 0; t < lat; t++) begin
        chk(mem_rd_valid === 1'b0 && req_ready === 1'b0, "R10 single outstanding",
            {63'd0, mem_rd_valid}, 64'd0);
        @(negedge clk);
      end
      d = dsq[k];
      mem_rsp_data = d; mem_rsp_valid = 1'b1;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = rnd64();

      // expected decode (R4, R5)
      if (lv == 3 || lv == first) begin
        if (!(d[0] && d[1])) begin fin = 1; e_flt = 1; end
        else if (lv == 3) fin = 1;
      end else begin
        if (!d[0]) begin fin = 1; e_flt = 1; end
        else if (!d[1]) fin = 1;
      end
      if (!fin) begin
        tbl = g ? {d[47:16], 16'd0} : {d[47:12], 12'd0};
        lv++; k++;
      end
    end

    if (!e_flt) begin
      if (g) begin
        osh = (lv == 2) ? 29 : 16;
        psh = (lv == 2) ? 29 : (d[52] ? 21 : 16);
      end else begin
        osh = (lv == 1) ? 30 : (lv == 2) ? 21 : 12;
        psh = (lv == 3 && d[52]) ? 16 : osh;
      end
      e_msk = ~((48'd1 << psh) - 48'd1);
      oa    = d[47:0] & ~((48'd1 << osh) - 48'd1);
      e_pa  = (oa & e_msk) | (va & ~e_msk);
      e_wr  = s2 ? (d[7:6] == 2'b11) : !d[7];
    end

    chk(done === 1'b1, "R11 done strobe", {63'd0, done}, 64'd1);
    chk(done_fault === e_flt, "R4 R5 fault flag", {63'd0, done_fault}, {63'd0, e_flt});
    chk(done_level === lv[1:0], "R6 final level", {62'd0, done_level}, {62'd0, lv[1:0]});
    chk(done_pa === e_pa, "R7 physical address", {16'd0, done_pa}, {16'd0, e_pa});
    chk(done_mask === e_msk, "R8 page mask", {16'd0, done_mask}, {16'd0, e_msk});
    chk(done_wr === e_wr, "R9 writable", {63'd0, done_wr}, {63'd0, e_wr});
    @(negedge clk);
    chk(done === 1'b0 && req_ready === 1'b1, "R11 single cycle done",
        {62'd0, done, req_ready}, 64'd1);
  endtask

  // table descriptors then a final one with given low bits
  task automatic build(input int nlev, input logic [1:0] lowb, input bit b52,
                       input logic [1:0] perm);
    for (int i = 0; i < nlev - 1; i++) dsq[i] = (rnd64() & ~64'h3) | 64'h3;
    dsq[nlev-1] = rnd64();
    dsq[nlev-1][1:0] = lowb;
    dsq[nlev-1][52]  = b52;
    dsq[nlev-1][7:6] = perm;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int wi = 0;
    do_reset();
    chk(req_ready === 1'b1, "R1 ready after reset", {63'd0, req_ready}, 64'd1);
    chk(mem_rd_valid === 1'b0, "R1 no read after reset", {63'd0, mem_rd_valid}, 64'd0);
    chk(done === 1'b0, "R1 no done after reset", {63'd0, done}, 64'd0);

    // mappings: every leaf level, bit 52, stage, permission bits (R7 R8 R9)
    for (int g = 0; g < 2; g++)
      for (int lf = 1; lf <= 3; lf++) begin
        if (g == 1 && lf == 1) continue;
        for (int b = 0; b < 2; b++)
          for (int s = 0; s < 2; s++)
            for (int p = 0; p < 4; p++) begin
              build(lf - (g ? 1 : 0) + 1, (lf == 3) ? 2'b11 : 2'b01, b[0], p[1:0]);
              walk(g[0], s[0], rnd64(), rnd64() & ~48'hFFF, wi % 3, wi % 4 == 1 ? 2 : 0);
              wi++;
            end
      end

    // faults at every level (R4 R5 R6)
    for (int g = 0; g < 2; g++)
      for (int lv = (g ? 1 : 0); lv <= 3; lv++)
        for (int kind = 0; kind < 3; kind++) begin
          logic [1:0] lb;
          if (kind == 0) lb = {$urandom_range(0, 1) == 1, 1'b0}; // valid bit clear
          else if (kind == 1 && lv == 3) lb = 2'b01;           // level-3 second bit clear
          else if (kind == 2 && lv == (g ? 1 : 0)) lb = 2'b01; // block at first level
          else continue;
          build(lv - (g ? 1 : 0) + 1, lb, 1'b1, 2'b11);
          walk(g[0], kind[0], rnd64(), rnd64() & ~48'hFFF, kind, 1);
        end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule